// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block sits between a bus master and the memory system and turns device virtual addresses into physical addresses. The mapping lives in memory as one flat array of 32-bit words. Each word covers one 4 KiB virtual page inside a window, called the aperture, and holds the physical page number for that page. An eight-entry fully associative cache of recent translations saves most table reads. On a miss the block issues one memory read for the needed word and holds the requester until the word comes back.

An access is never aborted. Some accesses cannot be translated: the page lies outside the aperture, or its table word is zero. These go to a fallback physical page instead. Reads and writes each have their own fallback page. A small register file holds the control bits, the table location, the aperture bounds and the two fallback pages. The control bits are translation on, a clock-gate request and pass-through. Software writes a dedicated register to drop every cached translation after it edits the table.

Top module: `flat_iommu`

## Requirements
- R1: After reset every writable register reads 0, register index 0 reads the version constant in bits 15:8 (0x0000_0100 by default), `clk_gate_en` is 0, and requests pass through unchanged.
- R2: When control bit 0 (translation on) is 0 or control bit 4 (pass-through) is 1, a request is accepted in the cycle it is presented. Its address is forwarded unchanged and no memory read is made.
- R3: A translated address equals the table word's low 20 bits shifted left by 12, ORed with the request's low 12 bits.
- R4: On a miss the block reads address base_page*4096 + 4*(vpn - first_vpn) and keeps `req_ready` low until the word has returned.
- R5: A page is inside the aperture when first_vpn <= vpn <= first_vpn + span. Outside it, the access is accepted at once without a memory read and goes to the read fallback page (`req_write`=0) or the write fallback page (`req_write`=1), keeping the low 12 bits.
- R6: A table word of zero redirects the access to the fallback page for its direction and is not cached, so the next access to that page reads the table again.
- R7: A request to a page held in the cache is accepted in the same cycle without a memory read.
- R8: Any write to register index 2 (flush) invalidates every cached translation.
- R9: A flush write that lands while a table read is outstanding stops the returned word from being cached. The waiting request is still served with it.
- R10: The cache holds 8 translations and replaces them in round-robin order of filling.
- R11: Registers by index: 1 control (bit 0 translation on, bit 1 clock-gate request driven on `clk_gate_en`, bit 4 pass-through), 3 table base page, 4 first vpn, 5 span, 6 read fallback page, 7 write fallback page. Each reads back as written; index 2 reads 0.
- R12: A memory read request holds its address stable until accepted, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_idx` |
| clk_gate_en | output | 1 | Clock-gate request bit from control |
| req_valid | input | 1 | Translation request valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Virtual address |
| req_ready | output | 1 | Request accepted, result valid |
| xlat_addr | output | 32 | Physical address |
| xlat_redirect | output | 1 | Result is a fallback page |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Table read accepted |
| mem_rd_addr | output | 32 | Table word address |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Table word |

## Verification
The hardest case to reach is a flush that arrives while a table read is in flight. The request, the read and the flush must overlap inside a window of a few cycles. The bench stretches that window: its memory model can delay both acceptance and response. It runs a flush register write in parallel with the stalled request and then touches the same page again. A fresh table read on that second access shows the late word was thrown away. Round-robin eviction is reached by filling nine distinct pages and checking which of them still hit.

// File: rtl/flat_iommu_pkg.sv
package flat_iommu_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PN_W       = ADDR_W - PAGE_SHIFT;
    localparam int IDX_W      = 3;

    localparam logic [IDX_W-1:0] IDX_VER   = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_FLUSH = 3'd2;
    localparam logic [IDX_W-1:0] IDX_BASE  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_FIRST = 3'd4;
    localparam logic [IDX_W-1:0] IDX_SPAN  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_DFRD  = 3'd6;
    localparam logic [IDX_W-1:0] IDX_DFWR  = 3'd7;

    typedef logic [PN_W-1:0] pn_t;

    typedef struct packed {
        logic en;
        logic gate;
        logic bypass;
        pn_t  base;
        pn_t  first;
        pn_t  span;
        pn_t  dflt_rd;
        pn_t  dflt_wr;
    } cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} st_t;
endpackage

// File: rtl/flat_iommu_regs.sv
module flat_iommu_regs
    import flat_iommu_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg,
    output logic              flush
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (idx)
                IDX_CTRL: begin
                    cfg_d.en     = wdata[0];
                    cfg_d.gate   = wdata[1];
                    cfg_d.bypass = wdata[4];
                end
                IDX_BASE:  cfg_d.base    = wdata[PN_W-1:0];
                IDX_FIRST: cfg_d.first   = wdata[PN_W-1:0];
                IDX_SPAN:  cfg_d.span    = wdata[PN_W-1:0];
                IDX_DFRD:  cfg_d.dflt_rd = wdata[PN_W-1:0];
                IDX_DFWR:  cfg_d.dflt_wr = wdata[PN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            IDX_VER:   rdata[15:8] = VERSION;
            IDX_CTRL:  rdata[4:0]  = {cfg_q.bypass, 2'b00, cfg_q.gate, cfg_q.en};
            IDX_BASE:  rdata = DATA_W'(cfg_q.base);
            IDX_FIRST: rdata = DATA_W'(cfg_q.first);
            IDX_SPAN:  rdata = DATA_W'(cfg_q.span);
            IDX_DFRD:  rdata = DATA_W'(cfg_q.dflt_rd);
            IDX_DFWR:  rdata = DATA_W'(cfg_q.dflt_wr);
            default:   rdata = '0;
        endcase
    end

    assign cfg   = cfg_q;
    assign flush = we && (idx == IDX_FLUSH);
endmodule

// File: rtl/flat_iommu_tlb.sv
module flat_iommu_tlb
    import flat_iommu_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  pn_t  look_vpn,
    output logic hit,
    output pn_t  hit_ppn,
    input  logic fill_en,
    input  pn_t  fill_vpn,
    input  pn_t  fill_ppn,
    input  logic flush
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]  valid;
        pn_t  [ENTRIES-1:0]  tag;
        pn_t  [ENTRIES-1:0]  ppn;
        logic [PTR_W-1:0]    ptr;
    } tlb_t;

    tlb_t tlb_d, tlb_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tlb_q.valid[g] && (tlb_q.tag[g] == look_vpn);
    end

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_ppn = hit_ppn | tlb_q.ppn[i];
        end
    end
    assign hit = |match;

    always_comb begin
        tlb_d = tlb_q;
        if (flush) begin
            tlb_d.valid = '0;
        end else if (fill_en) begin
            tlb_d.valid[tlb_q.ptr] = 1'b1;
            tlb_d.tag[tlb_q.ptr]   = fill_vpn;
            tlb_d.ppn[tlb_q.ptr]   = fill_ppn;
            tlb_d.ptr = (tlb_q.ptr == LAST) ? '0 : tlb_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tlb_q <= '0;
        else        tlb_q <= tlb_d;
    end
endmodule

// File: rtl/flat_iommu.sv
module flat_iommu
    import flat_iommu_pkg::*;
#(
    parameter int         TLB_ENTRIES = 8,
    parameter logic [7:0] VERSION     = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              clk_gate_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              xlat_redirect,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    typedef struct packed {
        st_t  st;
        pn_t  entry;
        logic stale;
    } ctl_t;

    cfg_t cfg;
    logic flush;
    logic tlb_hit, fill_en;
    pn_t  hit_ppn;
    ctl_t ctl_d, ctl_q;

    pn_t                  vpn, rel, dflt, rsp_pn;
    logic [PAGE_SHIFT-1:0] off;
    logic                 in_rng, passthru, busy;

    flat_iommu_regs #(.VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg), .flush(flush)
    );

    assign vpn      = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign off      = req_addr[PAGE_SHIFT-1:0];
    assign rel      = vpn - cfg.first;
    assign in_rng   = (vpn >= cfg.first) && (rel <= cfg.span);
    assign passthru = !cfg.en || cfg.bypass;
    assign dflt     = req_write ? cfg.dflt_wr : cfg.dflt_rd;
    assign rsp_pn   = mem_rsp_data[PN_W-1:0];
    assign busy     = (ctl_q.st != ST_IDLE);

    flat_iommu_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst_n(rst_n), .look_vpn(vpn), .hit(tlb_hit),
        .hit_ppn(hit_ppn), .fill_en(fill_en), .fill_vpn(vpn),
        .fill_ppn(rsp_pn), .flush(flush)
    );

    assign mem_rd_addr = {cfg.base, {PAGE_SHIFT{1'b0}}} + (ADDR_W'(rel) << 2);
    assign clk_gate_en = cfg.gate;

    always_comb begin
        ctl_d         = ctl_q;
        req_ready     = 1'b0;
        xlat_addr     = req_addr;
        xlat_redirect = 1'b0;
        mem_rd_valid  = 1'b0;
        fill_en       = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (passthru) begin
                        req_ready = 1'b1;
                    end else if (!in_rng) begin
                        req_ready     = 1'b1;
                        xlat_addr     = {dflt, off};
                        xlat_redirect = 1'b1;
                    end else if (tlb_hit) begin
                        req_ready = 1'b1;
                        xlat_addr = {hit_ppn, off};
                    end else begin
                        ctl_d.st    = ST_REQ;
                        ctl_d.stale = 1'b0;
                    end
                end
            end
            ST_REQ: begin
                mem_rd_valid = 1'b1;
                if (flush) ctl_d.stale = 1'b1;
                if (mem_rd_ready) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (flush) ctl_d.stale = 1'b1;
                if (mem_rsp_valid) begin
                    ctl_d.entry = rsp_pn;
                    ctl_d.st    = ST_DONE;
                    fill_en     = (rsp_pn != '0) && !ctl_q.stale && !flush;
                end
            end
            ST_DONE: begin
                req_ready = 1'b1;
                if (ctl_q.entry == '0) begin
                    xlat_addr     = {dflt, off};
                    xlat_redirect = 1'b1;
                end else begin
                    xlat_addr = {ctl_q.entry, off};
                end
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, entry: '0, stale: 1'b0};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/flat_iommu_chk.sv
module flat_iommu_chk
    import flat_iommu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic [ADDR_W-1:0] xlat_addr,
    input logic              xlat_redirect,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              cfg_en,
    input logic              cfg_bypass,
    input pn_t               dflt_rd,
    input pn_t               dflt_wr,
    input logic              flush,
    input logic              tlb_hit,
    input logic              busy
);
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

    a_r4_stall_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> xlat_addr[PAGE_SHIFT-1:0] == req_addr[PAGE_SHIFT-1:0]);

    a_r5_redirect_page: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && xlat_redirect |->
            xlat_addr[ADDR_W-1:PAGE_SHIFT] == (req_write ? dflt_wr : dflt_rd));

    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && (!cfg_en || cfg_bypass) |->
            req_ready && xlat_addr == req_addr && !xlat_redirect);

    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !tlb_hit);
endmodule

bind flat_iommu flat_iommu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .xlat_addr(xlat_addr),
    .xlat_redirect(xlat_redirect), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .cfg_en(cfg.en), .cfg_bypass(cfg.bypass), .dflt_rd(cfg.dflt_rd),
    .dflt_wr(cfg.dflt_wr), .flush(flush), .tlb_hit(tlb_hit), .busy(busy)
);

// File: tb/flat_iommu_test.sv
module flat_iommu_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] BASE  = 20'h40000;
    localparam logic [19:0] FIRST = 20'h00100;
    localparam logic [19:0] SPAN  = 20'd15;
    localparam logic [19:0] DFRD  = 20'hDEAD0;
    localparam logic [19:0] DFWR  = 20'hBEEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        clk_gate_en;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic [31:0] xlat_addr;
    logic        xlat_redirect;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int fetches = 0;
    int mem_lat = 1;
    int mem_stall = 1;
    logic [31:0] last_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flat_iommu uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .clk_gate_en(clk_gate_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .xlat_addr(xlat_addr), .xlat_redirect(xlat_redirect),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [19:0] ent(int idx);
        if (idx == 5) return 20'h0;
        return 20'h80000 | 20'(idx << 4) | 20'h1;
    endfunction

    function automatic logic [31:0] vaddr(int idx, logic [11:0] o);
        return {FIRST + 20'(idx), o};
    endfunction

    // memory model for table reads
    initial begin
        int lat_left = 0;
        int stall_left = 1;
        logic [31:0] pend = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rd_ready  = 1'b0;
            if (lat_left > 0) begin
                lat_left--;
                if (lat_left == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend;
                end
            end else if (mem_rd_valid) begin
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    mem_rd_ready = 1'b1;
                    fetches++;
                    last_addr = mem_rd_addr;
                    pend = {12'h0, ent(int'((mem_rd_addr - {BASE, 12'h0}) >> 2))};
                    lat_left = mem_lat;
                    stall_left = mem_stall;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(logic [2:0] idx, logic [31:0] exp, string req);
        @(negedge clk);
        cfg_idx = idx;
        #1;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    task automatic xlate(logic [31:0] a, bit wr, logic [31:0] exp, bit exp_red,
                         int exp_fetch, string req);
        int f0 = fetches;
        @(negedge clk);
        req_addr = a; req_write = wr; req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        chk(xlat_addr == exp, req, xlat_addr, exp);
        chk(xlat_redirect == exp_red, req, 32'(xlat_redirect), 32'(exp_red));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(fetches - f0 == exp_fetch, req, 32'(fetches - f0), 32'(exp_fetch));
    endtask

    task automatic t_reset;
        cfg_read(3'd0, 32'h0000_0100, "R1 version");
        cfg_read(3'd1, 32'h0, "R1 control");
        cfg_read(3'd3, 32'h0, "R1 base");
        chk(clk_gate_en == 1'b0, "R1 gate", 32'(clk_gate_en), 32'h0);
        xlate(32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0, 0, "R1 R2 passthrough after reset");
    endtask

    task automatic t_regs;
        cfg_write(3'd3, {12'h0, BASE});
        cfg_write(3'd4, {12'h0, FIRST});
        cfg_write(3'd5, {12'h0, SPAN});
        cfg_write(3'd6, {12'h0, DFRD});
        cfg_write(3'd7, {12'h0, DFWR});
        cfg_write(3'd1, 32'h0000_0013);
        cfg_read(3'd1, 32'h13, "R11 control");
        cfg_read(3'd3, {12'h0, BASE}, "R11 base");
        cfg_read(3'd4, {12'h0, FIRST}, "R11 first");
        cfg_read(3'd5, {12'h0, SPAN}, "R11 span");
        cfg_read(3'd6, {12'h0, DFRD}, "R11 rd page");
        cfg_read(3'd7, {12'h0, DFWR}, "R11 wr page");
        cfg_read(3'd2, 32'h0, "R11 flush reads 0");
        chk(clk_gate_en == 1'b1, "R11 gate", 32'(clk_gate_en), 32'h1);
    endtask

    task automatic t_bypass;
        xlate(vaddr(2, 12'h123), 1'b0, vaddr(2, 12'h123), 1'b0, 0, "R2 bypass");
        cfg_write(3'd1, 32'h0000_0003);
    endtask

    task automatic t_miss_hit;
        xlate(vaddr(2, 12'hABC), 1'b0, {ent(2), 12'hABC}, 1'b0, 1, "R3 R4 R12 miss");
        chk(last_addr == {BASE, 12'h008}, "R4 table address", last_addr, {BASE, 12'h008});
        xlate(vaddr(2, 12'h010), 1'b1, {ent(2), 12'h010}, 1'b0, 0, "R7 hit");
    endtask

    task automatic t_range;
        xlate({FIRST - 20'd1, 12'h444}, 1'b0, {DFRD, 12'h444}, 1'b1, 0, "R5 below read");
        xlate(vaddr(16, 12'h555), 1'b1, {DFWR, 12'h555}, 1'b1, 0, "R5 above write");
        xlate(vaddr(15, 12'h666), 1'b0, {ent(15), 12'h666}, 1'b0, 1, "R5 top page inside");
        chk(last_addr == {BASE, 12'h03C}, "R4 top address", last_addr, {BASE, 12'h03C});
    endtask

    task automatic t_zero;
        xlate(vaddr(5, 12'h0F0), 1'b0, {DFRD, 12'h0F0}, 1'b1, 1, "R6 zero entry read");
        xlate(vaddr(5, 12'h0F1), 1'b1, {DFWR, 12'h0F1}, 1'b1, 1, "R6 not cached");
    endtask

    task automatic t_flush;
        cfg_write(3'd2, 32'h0);
        xlate(vaddr(2, 12'h020), 1'b0, {ent(2), 12'h020}, 1'b0, 1, "R8 flush clears");
    endtask

    task automatic t_flush_mid;
        xlate(vaddr(3, 12'h001), 1'b0, {ent(3), 12'h001}, 1'b0, 1, "R9 prime");
        cfg_write(3'd2, 32'h0);
        mem_lat = 6;
        fork
            xlate(vaddr(4, 12'h002), 1'b0, {ent(4), 12'h002}, 1'b0, 1, "R9 served");
            begin
                repeat (3) @(negedge clk);
                cfg_write(3'd2, 32'hFFFF_FFFF);
            end
        join
        mem_lat = 1;
        xlate(vaddr(4, 12'h003), 1'b0, {ent(4), 12'h003}, 1'b0, 1, "R9 discarded");
    endtask

    task automatic t_round_robin;
        cfg_write(3'd2, 32'h0);
        for (int i = 6; i <= 14; i++)
            xlate(vaddr(i, 12'h100), 1'b0, {ent(i), 12'h100}, 1'b0, 1, "R10 fill");
        xlate(vaddr(6, 12'h101), 1'b0, {ent(6), 12'h101}, 1'b0, 1, "R10 oldest evicted");
        xlate(vaddr(8, 12'h102), 1'b0, {ent(8), 12'h102}, 1'b0, 0, "R10 survivor hit");
        xlate(vaddr(7, 12'h103), 1'b0, {ent(7), 12'h103}, 1'b0, 1, "R10 next evicted");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_bypass();
        t_miss_hit();
        t_range();
        t_zero();
        t_flush();
        t_flush_mid();
        t_round_robin();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule